// File: doc/BRIEF.md
# Bridge Legacy Video Window Claim Decoder

This block sits beside the address path of a two-port bus bridge. It watches the address phase on each port, a valid strobe, a 4-bit bus command and a 32-bit address, and decides whether the transaction targets the legacy video memory window or the legacy video I/O registers. If it does, and the port is the one the current mode selects, the block claims the transaction for forwarding to the other port. One clock after the address phase it reports the claim, the forwarding direction, which window matched, and the address to use on the far side. That address is the received address, with no translation.

A two-bit mode register picks the direction. It takes a preload value during reset and can then be rewritten by a configuration write from either port. Only one direction can be active at a time. The value that would enable both directions is illegal, and the block treats it as off, so its outputs stay defined.

Top module: `vga_fwd_decoder`

## Requirements
- R1: While `rst_n` is low, the mode register loads `boot_mode`. Out of reset, `claim`, `fwd_to_pri` and `hit_kind` are 0 and `fwd_addr` is 0.
- R2: In mode 01, matching phases on the primary port are claimed with `fwd_to_pri`=0. No secondary-port phase is claimed.
- R3: In mode 10, matching phases on the secondary port are claimed with `fwd_to_pri`=1. No primary-port phase is claimed.
- R4: In modes 00 and 11, nothing is claimed on either port.
- R5: Memory commands 0110 and 0111 match when the full 32-bit address lies in 000A0000h..000BFFFFh, both ends included. They report `hit_kind`=01.
- R6: I/O commands 0010 and 0011 match only when address bits [31:16] are zero. Bits [15:10] are ignored. Bits [9:0] in 3B0h..3BBh give `hit_kind`=10, and bits [9:0] in 3C0h..3DFh give `hit_kind`=11. The values 3BCh..3BFh do not match.
- R7: Every other command code is never claimed, whatever its address.
- R8: All outputs are registered and reflect the address phase of the previous clock. A cycle with no claimed phase gives `claim`=0, `fwd_to_pri`=0, `hit_kind`=00 and `fwd_addr`=0.
- R9: For a claimed phase, `fwd_addr` equals the address received on the claimed port, unchanged.
- R10: A configuration write updates the mode for phases from the next clock on. A phase in the same cycle as the write is decoded with the old mode.
- R11: When both ports write the mode in the same cycle, the primary port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Mode value loaded during reset |
| pcfg_we | input | 1 | Mode write strobe from the primary port |
| pcfg_mode | input | 2 | Mode value written from the primary port |
| scfg_we | input | 1 | Mode write strobe from the secondary port |
| scfg_mode | input | 2 | Mode value written from the secondary port |
| p_valid | input | 1 | Primary address phase valid |
| p_cmd | input | 4 | Primary bus command |
| p_addr | input | 32 | Primary address |
| s_valid | input | 1 | Secondary address phase valid |
| s_cmd | input | 4 | Secondary bus command |
| s_addr | input | 32 | Secondary address |
| claim | output | 1 | Previous phase is claimed for forwarding |
| fwd_to_pri | output | 1 | 1: forward toward primary; 0: toward secondary |
| hit_kind | output | 2 | 00 none, 01 memory, 10 I/O 3Bx, 11 I/O 3Cx/3Dx |
| fwd_addr | output | 32 | Address to present on the far port |

## Verification
A mode write and an address phase can land in the same cycle. So can a primary-port phase and a secondary-port phase. The bench issues a configuration write that flips the direction together with a matching phase. It expects that phase to be decoded under the old mode and the next one under the new mode. It also checks what happens when both ports write in the same cycle. Every sweep cell additionally drives both ports valid together and expects only the port chosen by the mode to be claimed.

// File: rtl/vga_fwd_pkg.sv
// Shared codes for the legacy video window claim decoder.
// Assumes bus command codes follow the common 4-bit encoding.
package vga_fwd_pkg;

    typedef enum logic [1:0] {
        HIT_NONE     = 2'b00,
        HIT_MEM      = 2'b01,
        HIT_IO_MONO  = 2'b10,
        HIT_IO_COLOR = 2'b11
    } hit_e;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_P2S = 2'b01;
    localparam logic [1:0] MODE_S2P = 2'b10;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/vga_mode_reg.sv
// Direction mode register. Loads a preload value during reset and accepts
// writes from either port afterwards; the A port wins a same-cycle clash.
// Assumes the caller maps A to the primary port.
module vga_mode_reg #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] boot_mode,
    input  logic              a_we,
    input  logic [MODE_W-1:0] a_mode,
    input  logic              b_we,
    input  logic [MODE_W-1:0] b_mode,
    output logic [MODE_W-1:0] mode_q
);

    // Preload on reset, then take a write with A-port priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= boot_mode;
        else if (a_we) mode_q <= a_mode;
        else if (b_we) mode_q <= b_mode;
    end

endmodule

// File: rtl/vga_range_match.sv
// Combinational legacy video window matcher for one port.
// Memory commands are checked against an inclusive full-width window.
// I/O commands are checked on the low IO_W bits, with the bits from
// IO_ZERO_LSB upward required to be zero and the bits between ignored.
module vga_range_match
    import vga_fwd_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [31:0]     MEM_LO      = 32'h000A_0000,
    parameter logic [31:0]     MEM_HI      = 32'h000B_FFFF,
    parameter int              IO_W        = 10,
    parameter int              IO_ZERO_LSB = 16,
    parameter logic [9:0]      MONO_LO     = 10'h3B0,
    parameter logic [9:0]      MONO_HI     = 10'h3BB,
    parameter logic [9:0]      COLOR_LO    = 10'h3C0,
    parameter logic [9:0]      COLOR_HI    = 10'h3DF
) (
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    output hit_e              hit
);

    localparam int HI_W = ADDR_W - IO_ZERO_LSB;

    logic            is_mem_cmd;
    logic            is_io_cmd;
    logic            mem_in;
    logic            io_upper_ok;
    logic [IO_W-1:0] io_low;

    assign is_mem_cmd  = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    assign is_io_cmd   = (cmd == CMD_IO_RD)  || (cmd == CMD_IO_WR);
    assign mem_in      = (addr >= ADDR_W'(MEM_LO)) && (addr <= ADDR_W'(MEM_HI));
    assign io_upper_ok = (addr[ADDR_W-1:IO_ZERO_LSB] == {HI_W{1'b0}});
    assign io_low      = addr[IO_W-1:0];

    // Classify the phase into one window or none.
    always_comb begin
        hit = HIT_NONE;
        if (is_mem_cmd && mem_in) begin
            hit = HIT_MEM;
        end else if (is_io_cmd && io_upper_ok) begin
            if ((io_low >= IO_W'(MONO_LO)) && (io_low <= IO_W'(MONO_HI)))
                hit = HIT_IO_MONO;
            else if ((io_low >= IO_W'(COLOR_LO)) && (io_low <= IO_W'(COLOR_HI)))
                hit = HIT_IO_COLOR;
        end
    end

endmodule

// File: rtl/vga_claim_stage.sv
// Output register stage. Captures a claim decision with its direction,
// window and address; clears every field when nothing is claimed.
module vga_claim_stage #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              dir_in,
    input  logic [1:0]        kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              claim,
    output logic              dir,
    output logic [1:0]        kind,
    output logic [ADDR_W-1:0] addr
);

    // Register the decision, or clear to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            claim <= 1'b0;
            dir   <= 1'b0;
            kind  <= 2'b00;
            addr  <= '0;
        end else begin
            claim <= 1'b1;
            dir   <= dir_in;
            kind  <= kind_in;
            addr  <= addr_in;
        end
    end

endmodule

// File: rtl/vga_fwd_decoder.sv
// Legacy video window claim decoder for a two-port bridge.
// One matcher per port; the mode register picks which port may claim.
// Modes 00 and 11 disable claiming. The output lags the phase by one clock.
module vga_fwd_decoder
    import vga_fwd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_mode,
    input  logic              pcfg_we,
    input  logic [1:0]        pcfg_mode,
    input  logic              scfg_we,
    input  logic [1:0]        scfg_mode,
    input  logic              p_valid,
    input  logic [3:0]        p_cmd,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic              s_valid,
    input  logic [3:0]        s_cmd,
    input  logic [ADDR_W-1:0] s_addr,
    output logic              claim,
    output logic              fwd_to_pri,
    output logic [1:0]        hit_kind,
    output logic [ADDR_W-1:0] fwd_addr
);

    localparam int NPORT = 2;

    logic [1:0]        mode_q;
    logic [3:0]        cmd_a  [NPORT];
    logic [ADDR_W-1:0] addr_a [NPORT];
    logic              vld_a  [NPORT];
    hit_e              hit_a  [NPORT];

    logic              take_d;
    logic              dir_d;
    logic [1:0]        kind_d;
    logic [ADDR_W-1:0] addr_d;

    assign cmd_a[0]  = p_cmd;
    assign cmd_a[1]  = s_cmd;
    assign addr_a[0] = p_addr;
    assign addr_a[1] = s_addr;
    assign vld_a[0]  = p_valid;
    assign vld_a[1]  = s_valid;

    vga_mode_reg #(.MODE_W(2)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .a_we      (pcfg_we),
        .a_mode    (pcfg_mode),
        .b_we      (scfg_we),
        .b_mode    (scfg_mode),
        .mode_q    (mode_q)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        vga_range_match #(.ADDR_W(ADDR_W)) u_match (
            .cmd  (cmd_a[g]),
            .addr (addr_a[g]),
            .hit  (hit_a[g])
        );
    end

    // Select the port the mode enables and form the claim decision.
    always_comb begin
        take_d = 1'b0;
        dir_d  = 1'b0;
        kind_d = 2'b00;
        addr_d = '0;
        if (mode_q == MODE_P2S && vld_a[0] && hit_a[0] != HIT_NONE) begin
            take_d = 1'b1;
            dir_d  = 1'b0;
            kind_d = hit_a[0];
            addr_d = addr_a[0];
        end else if (mode_q == MODE_S2P && vld_a[1] && hit_a[1] != HIT_NONE) begin
            take_d = 1'b1;
            dir_d  = 1'b1;
            kind_d = hit_a[1];
            addr_d = addr_a[1];
        end
    end

    vga_claim_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take_d),
        .dir_in  (dir_d),
        .kind_in (kind_d),
        .addr_in (addr_d),
        .claim   (claim),
        .dir     (fwd_to_pri),
        .kind    (hit_kind),
        .addr    (fwd_addr)
    );

endmodule

// File: rtl/vga_fwd_checker.sv
// Property checker for the claim decoder, bound onto every instance.
module vga_fwd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              p_valid,
    input logic [ADDR_W-1:0] p_addr,
    input logic              s_valid,
    input logic [ADDR_W-1:0] s_addr,
    input logic              claim,
    input logic              fwd_to_pri,
    input logic [1:0]        hit_kind,
    input logic [ADDR_W-1:0] fwd_addr
);

    // R2
    p2s_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !fwd_to_pri) |-> ($past(mode) == 2'b01 && $past(p_valid)));

    // R3
    s2p_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && fwd_to_pri) |-> ($past(mode) == 2'b10 && $past(s_valid)));

    // R4
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> !claim);

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_valid && !s_valid) |=> (!claim && hit_kind == 2'b00 && fwd_addr == '0));

    // R9
    p_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !fwd_to_pri) |-> fwd_addr == $past(p_addr));

    // R9
    s_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && fwd_to_pri) |-> fwd_addr == $past(s_addr));

    // R6
    io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && hit_kind[1]) |-> fwd_addr[ADDR_W-1:16] == '0);

endmodule

bind vga_fwd_decoder vga_fwd_checker #(.ADDR_W(ADDR_W)) u_fwd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .p_valid    (p_valid),
    .p_addr     (p_addr),
    .s_valid    (s_valid),
    .s_addr     (s_addr),
    .claim      (claim),
    .fwd_to_pri (fwd_to_pri),
    .hit_kind   (hit_kind),
    .fwd_addr   (fwd_addr)
);

// File: tb/test_vga_fwd_decoder.sv
`timescale 1ns/1ps
// Sweep bench: every mode x command x boundary address x port combination,
// a full low-address I/O sweep, and same-cycle write/phase cases.
module test_vga_fwd_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  boot_mode;
    logic        pcfg_we, scfg_we;
    logic [1:0]  pcfg_mode, scfg_mode;
    logic        p_valid, s_valid;
    logic [3:0]  p_cmd, s_cmd;
    logic [31:0] p_addr, s_addr;
    logic        claim, fwd_to_pri;
    logic [1:0]  hit_kind;
    logic [31:0] fwd_addr;

    int errors = 0;
    int checks = 0;
    logic [1:0] mdl_mode;

    always #2.5 clk = ~clk;

    vga_fwd_decoder i_vga_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .pcfg_we(pcfg_we), .pcfg_mode(pcfg_mode),
        .scfg_we(scfg_we), .scfg_mode(scfg_mode),
        .p_valid(p_valid), .p_cmd(p_cmd), .p_addr(p_addr),
        .s_valid(s_valid), .s_cmd(s_cmd), .s_addr(s_addr),
        .claim(claim), .fwd_to_pri(fwd_to_pri),
        .hit_kind(hit_kind), .fwd_addr(fwd_addr)
    );

    // Window classification computed from R5, R6, R7.
    function automatic logic [1:0] exp_kind(logic [3:0] c, logic [31:0] a);
        if (c == 4'h6 || c == 4'h7)
            return (a >= 32'h000A_0000 && a <= 32'h000B_FFFF) ? 2'b01 : 2'b00;
        if ((c == 4'h2 || c == 4'h3) && a[31:16] == 16'h0) begin
            if (a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) return 2'b10;
            if (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF) return 2'b11;
        end
        return 2'b00;
    endfunction

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, check the registered result
    // at the next falling edge, then update the mode model (R10, R11).
    task automatic apply(logic pv, logic [3:0] pc, logic [31:0] pa,
                         logic sv, logic [3:0] sc, logic [31:0] sa,
                         logic pwe, logic [1:0] pm, logic swe, logic [1:0] sm,
                         string tag);
        logic [1:0]  pk, sk, ek;
        logic        ec, ed;
        logic [31:0] ea;
        p_valid = pv; p_cmd = pc; p_addr = pa;
        s_valid = sv; s_cmd = sc; s_addr = sa;
        pcfg_we = pwe; pcfg_mode = pm; scfg_we = swe; scfg_mode = sm;
        pk = exp_kind(pc, pa);
        sk = exp_kind(sc, sa);
        ec = 1'b0; ed = 1'b0; ek = 2'b00; ea = 32'h0;
        if (mdl_mode == 2'b01 && pv && pk != 2'b00) begin
            ec = 1'b1; ek = pk; ea = pa;
        end else if (mdl_mode == 2'b10 && sv && sk != 2'b00) begin
            ec = 1'b1; ed = 1'b1; ek = sk; ea = sa;
        end
        if (pwe) mdl_mode = pm;
        else if (swe) mdl_mode = sm;
        @(negedge clk);
        chk(tag, {claim, fwd_to_pri, hit_kind, fwd_addr}, {ec, ed, ek, ea});
    endtask

    task automatic set_mode(logic [1:0] m);
        apply(1'b0, 4'h0, 32'h0, 1'b0, 4'h0, 32'h0, 1'b1, m, 1'b0, 2'b00, "R10 setmode");
    endtask

    function automatic logic [31:0] sweep_addr(int k);
        case (k)
            0:  return 32'h0009_FFFF;
            1:  return 32'h000A_0000;
            2:  return 32'h000B_0000;
            3:  return 32'h000B_FFFF;
            4:  return 32'h000C_0000;
            5:  return 32'h010A_0000;
            6:  return 32'h0000_03AF;
            7:  return 32'h0000_03B0;
            8:  return 32'h0000_03BB;
            9:  return 32'h0000_03BC;
            10: return 32'h0000_03BF;
            11: return 32'h0000_03C0;
            12: return 32'h0000_03DF;
            13: return 32'h0000_03E0;
            14: return 32'h0000_FFB5;
            default: return 32'h0001_03C4;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string tg;
        rst_n = 1'b0; boot_mode = 2'b01;
        pcfg_we = 0; pcfg_mode = 0; scfg_we = 0; scfg_mode = 0;
        p_valid = 1; p_cmd = 4'h6; p_addr = 32'h000A_0000;
        s_valid = 0; s_cmd = 0; s_addr = 0;
        mdl_mode = 2'b01;
        repeat (3) @(negedge clk);
        // R1: reset clears outputs even with a matching phase present
        chk("R1 reset outputs", {claim, fwd_to_pri, hit_kind, fwd_addr}, 36'h0);
        rst_n = 1'b1;
        // R1: preloaded mode 01 lets a primary phase be claimed
        apply(1, 4'h6, 32'h000A_0000, 0, 0, 0, 0, 0, 0, 0, "R1 preload claim");
        // R8: idle cycle clears outputs
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle clear");

        // Main sweep: mode x command x address x port pattern
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 16; k++) begin
                    tg = (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
                    tg = {tg, (c == 6 || c == 7) ? " R5" : (c == 2 || c == 3) ? " R6" : " R7", " R9"};
                    apply(1, 4'(c), sweep_addr(k), 0, 0, 0, 0, 0, 0, 0, {tg, " pri"});
                    apply(0, 0, 0, 1, 4'(c), sweep_addr(k), 0, 0, 0, 0, {tg, " sec"});
                    apply(1, 4'(c), sweep_addr(k), 1, 4'(c), sweep_addr(15 - k),
                          0, 0, 0, 0, {tg, " both"});
                end
            end
        end

        // R6: every low 10-bit I/O value on the secondary port, with aliases
        set_mode(2'b10);
        for (int i = 0; i < 1024; i++)
            apply(0, 0, 0, 1, 4'h3, {16'h0, 6'(i * 7), 10'(i)}, 0, 0, 0, 0, "R6 io sweep");

        // R10: write to mode 01 in the same cycle as a secondary phase
        apply(0, 0, 0, 1, 4'h2, 32'h0000_03C4, 1, 2'b01, 0, 0, "R10 old mode same cycle");
        apply(0, 0, 0, 1, 4'h2, 32'h0000_03C4, 0, 0, 0, 0, "R10 new mode blocks sec");
        apply(1, 4'h7, 32'h000B_FFFF, 0, 0, 0, 0, 0, 1, 2'b00, "R10 sec write same cycle");
        apply(1, 4'h7, 32'h000B_FFFF, 0, 0, 0, 0, 0, 0, 0, "R10 mode 00 after write");

        // R11: simultaneous writes, primary value kept
        apply(0, 0, 0, 0, 0, 0, 1, 2'b01, 1, 2'b10, "R11 dual write");
        apply(1, 4'h2, 32'h0000_03B4, 0, 0, 0, 0, 0, 0, 0, "R11 primary wins pri");
        apply(0, 0, 0, 1, 4'h2, 32'h0000_03B4, 0, 0, 0, 0, "R11 primary wins sec");
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle end");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule